// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block is a hardware master for the byte-wide slave configuration port of a target FPGA. A single start pulse runs the whole load. The block pulses the target's program line low and waits for its init line to fall and then rise again. It then selects the port, asserts the write strobe and lets a settling interval pass. After that it moves a caller-supplied number of bytes from a valid/ready byte stream onto the 8-bit data bus, one configuration clock pulse per byte.

While streaming, the block samples the init line before every byte. A low init line means the target found a configuration (CRC) error, and the load is aborted. The busy line can be honoured after each clock pulse, or ignored, under control of an input. After the last byte the strobes are released and the block waits for the done and init lines to be high together.

Every wait has its own timeout, counted in system clock cycles. The outcome is reported on a status code that holds until the next start. The target-side inputs are assumed to be synchronous to the system clock.

Top module: `pcfg_loader`

## Requirements
- R1: After reset the program line, select, write strobe and configuration clock outputs are all high, `s_ready_o` is low and `status_o` is IDLE (code 0).
- R2: A start pulse in IDLE drives the program line low. It stays low for at least PROG_CYC cycles and until the init input is low, then it is released. The low pulse lasts exactly max(PROG_CYC, k) cycles, where the init input is seen low in the k-th cycle of the pulse. Select stays high while the program line is low.
- R3: If the init input is not low within INIT_TO_CYC cycles of the program pulse start, or not high again within INIT_TO_CYC cycles of its release, the load ends with status ERR_INIT_TIMEOUT (code 3), program line and select high. An init edge seen in the last cycle of the window still counts as in time.
- R4: Once the init input is high, select and write strobe go low together. No byte is accepted for SETTLE_CYC cycles, so with the stream ready the configuration clock first goes low SETTLE_CYC+1 cycles after select falls.
- R5: Each byte accepted on a valid/ready handshake appears on `data_o`. The configuration clock goes low for exactly one cycle starting with the next cycle, and rises with `data_o` unchanged. Exactly `byte_cnt_i` bytes (latched at start) are delivered in order, and zero bytes is allowed.
- R6: While `s_valid_i` is low the configuration clock stays high and no byte is consumed. A stalled stream still delivers every byte exactly once.
- R7: In a cycle where bytes remain and the init input is low, `s_ready_o` is low, no byte is consumed and the load ends with status ERR_CRC (code 4).
- R8: With `busy_en_i` high, after each configuration clock rise the next byte waits until the busy input is low. If busy stays high for BUSY_TO_CYC cycles, the load ends with ERR_BUSY_TIMEOUT (code 5). With `busy_en_i` low the busy input has no effect.
- R9: After the last byte, select and write strobe go high. Status OK (code 2) follows if done and init are seen high together within DONE_TO_CYC cycles; otherwise ERR_DONE_TIMEOUT (code 6). Done arriving in the last cycle of the window gives OK.
- R10: `status_o` is BUSY (code 1) from the cycle after the accepted start until the end. The final code holds until the next start, and start pulses during a load are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a load (accepted in IDLE only) |
| busy_en_i | input | 1 | Honour the busy input after each byte |
| byte_cnt_i | input | CNT_W | Number of bytes to stream, latched at start |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Stream byte accepted this cycle when valid |
| prog_n_o | output | 1 | Target program line, active low |
| init_n_i | input | 1 | Target init line, low means reset or error |
| done_i | input | 1 | Target done line |
| busy_i | input | 1 | Target busy line |
| cs_n_o | output | 1 | Target port select, active low |
| wr_n_o | output | 1 | Target write strobe, active low |
| cclk_o | output | 1 | Configuration clock, byte taken on rise |
| data_o | output | 8 | Configuration data bus |
| status_o | output | 3 | Status code: 0 IDLE, 1 BUSY, 2 OK, 3..6 errors |

## Verification
The sharpest collision is a target response arriving in the same cycle that its timeout window closes. In the done wait, the done line can rise exactly in the final cycle; the same can happen to the init fall after the program pulse. The bench places the target model's response delay exactly at the window length and one cycle beyond it. It expects OK or in-time progress for the first and the timeout code for the second. A second collision, init falling while a byte is valid, is provoked by a model that drops init right after a chosen byte. The bench judges it by the exact count of bytes the model captured.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_OK     = 3'd2,
    ST_E_INIT = 3'd3,
    ST_E_CRC  = 3'd4,
    ST_E_BUSY = 3'd5,
    ST_E_DONE = 3'd6
  } cfgl_status_e;

  typedef enum logic [2:0] {
    F_IDLE,
    F_PROG,
    F_INIT_HI,
    F_SETTLE,
    F_CHECK,
    F_CLK_LO,
    F_BUSY,
    F_FINISH
  } cfgl_fsm_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfgl_timer.sv
module cfgl_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/cfgl_bytes.sv
module cfgl_bytes #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  input  logic         dec_i,
  output logic         empty_o
);

  logic [W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rem_q <= '0;
    else if (load_i)  rem_q <= len_i;
    else if (dec_i)   rem_q <= rem_q - 1'b1;
  end

  assign empty_o = (rem_q == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (rem_q != '0)); // R5

endmodule

// File: rtl/pcfg_loader.sv
module pcfg_loader
  import cfgl_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned PROG_CYC    = (CLK_HZ / 1_000_000) * 3 / 10 + 1,
  parameter int unsigned INIT_TO_CYC = CLK_HZ / 2,
  parameter int unsigned SETTLE_CYC  = CLK_HZ / 100,
  parameter int unsigned BUSY_TO_CYC = CLK_HZ / 200,
  parameter int unsigned DONE_TO_CYC = CLK_HZ / 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             busy_en_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  output logic             s_ready_o,
  output logic             prog_n_o,
  input  logic             init_n_i,
  input  logic             done_i,
  input  logic             busy_i,
  output logic             cs_n_o,
  output logic             wr_n_o,
  output logic             cclk_o,
  output logic [7:0]       data_o,
  output logic [2:0]       status_o
);

  localparam int unsigned TMAX  = max_u(max_u(max_u(PROG_CYC, INIT_TO_CYC), max_u(SETTLE_CYC, BUSY_TO_CYC)),
                                        DONE_TO_CYC);
  localparam int unsigned TMR_W = $clog2(TMAX + 1);

  localparam logic [TMR_W-1:0] LIM_PROG = TMR_W'(PROG_CYC - 1);
  localparam logic [TMR_W-1:0] LIM_INIT = TMR_W'(INIT_TO_CYC - 1);
  localparam logic [TMR_W-1:0] LIM_SET  = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0] LIM_BUSY = TMR_W'(BUSY_TO_CYC - 1);
  localparam logic [TMR_W-1:0] LIM_DONE = TMR_W'(DONE_TO_CYC - 1);

  cfgl_fsm_e      state_q, state_d;
  cfgl_status_e   status_q, status_d;
  logic           prog_n_q, sel_q, cclk_q;
  logic [7:0]     data_q;
  logic [TMR_W-1:0] tmr_cnt, lim_sel;
  logic           tmr_clr, tmo, prog_min_ok;
  logic           load, empty, ready, accept;

  cfgl_timer #(.W(TMR_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .cnt_o  (tmr_cnt)
  );

  cfgl_bytes #(.W(CNT_W)) u_bytes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .len_i   (byte_cnt_i),
    .dec_i   (accept),
    .empty_o (empty)
  );

  always_comb begin
    unique case (state_q)
      F_SETTLE: lim_sel = LIM_SET;
      F_BUSY:   lim_sel = LIM_BUSY;
      F_FINISH: lim_sel = LIM_DONE;
      default:  lim_sel = LIM_INIT;
    endcase
  end

  assign tmo         = (tmr_cnt >= lim_sel);
  assign prog_min_ok = (tmr_cnt >= LIM_PROG);

  // init is checked before every byte; a failing byte is never consumed
  assign ready  = (state_q == F_CHECK) && !empty && init_n_i;
  assign accept = ready && s_valid_i;

  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    load     = 1'b0;
    unique case (state_q)
      F_IDLE: begin
        if (start_i) begin
          state_d  = F_PROG;
          status_d = ST_RUN;
          load     = 1'b1;
        end
      end
      F_PROG: begin
        if (!init_n_i && prog_min_ok) state_d = F_INIT_HI;
        else if (tmo) begin
          state_d  = F_IDLE;
          status_d = ST_E_INIT;
        end
      end
      F_INIT_HI: begin
        if (init_n_i) state_d = F_SETTLE;
        else if (tmo) begin
          state_d  = F_IDLE;
          status_d = ST_E_INIT;
        end
      end
      F_SETTLE: begin
        if (tmo) state_d = F_CHECK;
      end
      F_CHECK: begin
        if (empty) state_d = F_FINISH;
        else if (!init_n_i) begin
          state_d  = F_IDLE;
          status_d = ST_E_CRC;
        end else if (s_valid_i) state_d = F_CLK_LO;
      end
      F_CLK_LO: begin
        state_d = busy_en_i ? F_BUSY : F_CHECK;
      end
      F_BUSY: begin
        if (!busy_i) state_d = F_CHECK;
        else if (tmo) begin
          state_d  = F_IDLE;
          status_d = ST_E_BUSY;
        end
      end
      F_FINISH: begin
        if (done_i && init_n_i) begin
          state_d  = F_IDLE;
          status_d = ST_OK;
        end else if (tmo) begin
          state_d  = F_IDLE;
          status_d = ST_E_DONE;
        end
      end
      default: state_d = F_IDLE;
    endcase
  end

  assign tmr_clr = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= F_IDLE;
      status_q <= ST_IDLE;
      prog_n_q <= 1'b1;
      sel_q    <= 1'b0;
      cclk_q   <= 1'b1;
      data_q   <= '0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      prog_n_q <= (state_d != F_PROG);
      sel_q    <= (state_d == F_SETTLE) || (state_d == F_CHECK) ||
                  (state_d == F_CLK_LO) || (state_d == F_BUSY);
      cclk_q   <= (state_d != F_CLK_LO);
      if (accept) data_q <= s_data_i;
    end
  end

  assign s_ready_o = ready;
  assign prog_n_o  = prog_n_q;
  assign cs_n_o    = ~sel_q;
  assign wr_n_o    = ~sel_q;
  assign cclk_o    = cclk_q;
  assign data_o    = data_q;
  assign status_o  = status_q;

  // checker-only width counter for the program pulse
  logic [TMR_W-1:0] prog_w_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               prog_w_q <= '0;
    else if (prog_n_o)         prog_w_q <= '0;
    else if (prog_w_q != '1)   prog_w_q <= prog_w_q + 1'b1;
  end

  AST_PROG_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_n_o) |-> (prog_w_q >= TMR_W'(PROG_CYC))); // R2

  AST_PROG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_n_o |-> (cs_n_o && cclk_o)); // R2

  AST_INIT_ERR_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_E_INIT) |-> (prog_n_o && cs_n_o)); // R3

  AST_CCLK_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cclk_o |=> cclk_o); // R5

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cclk_o) |-> $stable(data_o)); // R5

  AST_CCLK_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cclk_o |-> (!cs_n_o && !wr_n_o)); // R5

  AST_READY_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> init_n_i); // R7

  AST_OK_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o == ST_OK) |-> $past(done_i && init_n_i)); // R9

  AST_OK_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_OK) |-> (cs_n_o && wr_n_o)); // R9

  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o >= ST_OK) && !start_i) |=> $stable(status_o)); // R10

endmodule

// File: tb/pcfg_loader_tb_top.sv
`timescale 1ns/1ps
module pcfg_loader_tb_top;

  localparam int PC  = 4;
  localparam int ITO = 20;
  localparam int SET = 5;
  localparam int BTO = 6;
  localparam int DTO = 15;
  localparam int CW  = 8;

  localparam int C_IDLE = 0, C_RUN = 1, C_OK = 2, C_EINIT = 3, C_ECRC = 4, C_EBUSY = 5, C_EDONE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy_en = 1'b0;
  logic [CW-1:0] byte_cnt = '0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, prog_n, cs_n, wr_n, cclk;
  logic init_r = 1'b1, done_r = 1'b0, busy_r = 1'b0;
  logic [7:0] data;
  logic [2:0] status;

  always #2 clk = ~clk;

  pcfg_loader #(
    .CLK_HZ(1000), .CNT_W(CW), .PROG_CYC(PC), .INIT_TO_CYC(ITO),
    .SETTLE_CYC(SET), .BUSY_TO_CYC(BTO), .DONE_TO_CYC(DTO)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_en_i(busy_en),
    .byte_cnt_i(byte_cnt), .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
    .prog_n_o(prog_n), .init_n_i(init_r), .done_i(done_r), .busy_i(busy_r),
    .cs_n_o(cs_n), .wr_n_o(wr_n), .cclk_o(cclk), .data_o(data), .status_o(status)
  );

  // target model knobs
  int fall_dly = 1, rise_dly = 3, busy_len = 2, done_dly = 3, crc_at = -1;
  bit no_fall = 0, no_rise = 0, done_en = 1, stall = 0, extra_start = 0;
  bit clr_model = 0;
  int n_total = 0;
  int seed = 0;

  // target model state
  int pcnt, rcnt, nbytes, bcnt, dcnt, pfalls, prog_w, set_w, lowcnt, cyc;
  bit seen_sel, prev_cclk, prev_prog, crc_hit, first_low;
  logic [7:0] cap [64];

  int n_chk = 0, n_fail = 0;

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'((i * 37 + s * 11 + 5) & 8'hFF);
  endfunction

  always @(negedge clk) begin
    if (clr_model) begin
      pcnt = 0; rcnt = 0; nbytes = 0; bcnt = 0; dcnt = 0; pfalls = 0; prog_w = 0;
      set_w = 0; lowcnt = 0; cyc = 0; seen_sel = 0; prev_cclk = 1; prev_prog = 1;
      crc_hit = 0; first_low = 0; init_r = 1; done_r = 0; busy_r = 0; s_valid = 0;
    end else begin
      cyc++;
      if (prev_prog && !prog_n) pfalls++;
      if (!prog_n) begin
        pcnt++; prog_w++; rcnt = 0; done_r = 0; crc_hit = 0;
        if (!no_fall && pcnt >= fall_dly) init_r = 0;
      end else if (!init_r && !crc_hit) begin
        rcnt++;
        if (!no_rise && rcnt >= rise_dly) init_r = 1;
      end
      if (!prev_cclk && cclk && !cs_n && !wr_n) begin
        if (nbytes < 64) cap[nbytes] = data;
        nbytes++;
        bcnt = busy_len;
        if (nbytes == crc_at) begin crc_hit = 1; init_r = 0; end
      end else if (bcnt > 0) bcnt--;
      busy_r = (bcnt > 0);
      if (!cclk) begin lowcnt++; first_low = 1; end
      if (!cs_n && cclk && nbytes == 0 && !first_low) set_w++;
      if (!cs_n) seen_sel = 1;
      if (cs_n && seen_sel) begin
        dcnt++;
        if (done_en && dcnt >= done_dly) done_r = 1;
      end
      s_valid = (nbytes < n_total) && !(stall && (cyc % 3 == 0));
      s_data  = pat(nbytes, seed);
      prev_cclk = cclk;
      prev_prog = prog_n;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic set_defaults();
    fall_dly = 1; rise_dly = 3; busy_len = 2; done_dly = 3; crc_at = -1;
    no_fall = 0; no_rise = 0; done_en = 1; stall = 0; extra_start = 0;
  endtask

  task automatic run_cfg(input int n, input bit ben, input int exp_st, input int exp_n, input string rq);
    int k;
    int bad;
    logic [2:0] fin;
    seed++;
    n_total = n;
    @(posedge clk); #1 clr_model = 1;
    @(posedge clk); #1 clr_model = 0;
    byte_cnt = CW'(n); busy_en = ben; start = 1;
    @(posedge clk); #1 start = 0;
    @(negedge clk);
    chk(status == 3'(C_RUN), "R10 status busy", status, C_RUN);
    if (extra_start) begin
      repeat (12) @(posedge clk);
      #1 start = 1;
      @(posedge clk); #1 start = 0;
    end
    k = 0;
    while (status == 3'(C_RUN) && k < 3000) begin @(negedge clk); k++; end
    chk(k < 3000, {rq, " run ended"}, k, 3000);
    chk(status == 3'(exp_st), {rq, " final status"}, status, exp_st);
    chk(nbytes == exp_n, {rq, " bytes captured"}, nbytes, exp_n);
    bad = 0;
    for (int i = 0; i < exp_n && i < 64; i++) if (cap[i] !== pat(i, seed)) bad++;
    chk(bad == 0, "R5 byte values and order", bad, 0);
    chk(prog_n && cs_n && wr_n && cclk, "R9 lines released", {prog_n, cs_n, wr_n, cclk}, 4'hF);
    fin = status;
    repeat (20) @(negedge clk);
    chk(status == fin, "R10 status holds", status, fin);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clr_model = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(prog_n === 1'b1, "R1 prog high", prog_n, 1);
    chk(cs_n === 1'b1 && wr_n === 1'b1, "R1 strobes high", {cs_n, wr_n}, 3);
    chk(cclk === 1'b1, "R1 cclk high", cclk, 1);
    chk(s_ready === 1'b0, "R1 ready low", s_ready, 0);
    chk(status === 3'(C_IDLE), "R1 status idle", status, C_IDLE);
    clr_model = 0;

    // sweep of lengths with busy on and off
    for (int n = 1; n <= 6; n++) begin
      for (int b = 0; b < 2; b++) begin
        set_defaults();
        run_cfg(n, b[0], C_OK, n, "R5 sweep");
        chk(prog_w == PC, "R2 pulse width min", prog_w, PC);
        chk(set_w == SET + 1, "R4 settle before first clock", set_w, SET + 1);
        chk(lowcnt == n, "R5 one clock low per byte", lowcnt, n);
      end
    end

    set_defaults(); fall_dly = 9;
    run_cfg(3, 0, C_OK, 3, "R2 late init fall");
    chk(prog_w == 9, "R2 pulse width follows init", prog_w, 9);

    set_defaults(); fall_dly = ITO;
    run_cfg(2, 0, C_OK, 2, "R3 init fall in last cycle");
    chk(prog_w == ITO, "R3 pulse width at edge", prog_w, ITO);

    set_defaults(); fall_dly = ITO + 1;
    run_cfg(2, 0, C_EINIT, 0, "R3 init fall one late");
    chk(prog_w == ITO, "R3 timeout width", prog_w, ITO);

    set_defaults(); no_fall = 1;
    run_cfg(2, 0, C_EINIT, 0, "R3 init never falls");

    set_defaults(); no_rise = 1;
    run_cfg(2, 0, C_EINIT, 0, "R3 init never rises");
    chk(seen_sel == 0, "R3 select never asserted", seen_sel, 0);

    set_defaults(); crc_at = 2;
    run_cfg(5, 0, C_ECRC, 2, "R7 crc abort");
    set_defaults(); crc_at = 3;
    run_cfg(5, 1, C_ECRC, 3, "R7 crc abort with busy");

    set_defaults(); busy_len = 20;
    run_cfg(4, 1, C_EBUSY, 1, "R8 busy timeout");
    set_defaults(); busy_len = 20;
    run_cfg(4, 0, C_OK, 4, "R8 busy ignored when off");

    set_defaults(); done_en = 0;
    run_cfg(3, 0, C_EDONE, 3, "R9 done never");
    set_defaults(); done_dly = DTO;
    run_cfg(3, 0, C_OK, 3, "R9 done in last cycle");
    set_defaults(); done_dly = DTO + 1;
    run_cfg(3, 0, C_EDONE, 3, "R9 done one late");

    set_defaults();
    run_cfg(0, 0, C_OK, 0, "R5 zero bytes");

    set_defaults(); stall = 1;
    run_cfg(6, 0, C_OK, 6, "R6 stalled stream");
    chk(lowcnt == 6, "R6 no clock during stall", lowcnt, 6);
    set_defaults(); stall = 1;
    run_cfg(6, 1, C_OK, 6, "R6 stalled stream busy");

    set_defaults(); stall = 1; extra_start = 1;
    run_cfg(6, 0, C_OK, 6, "R10 start during load");
    chk(pfalls == 1, "R10 single program pulse", pfalls, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule